// File: doc/BRIEF.md
# Repeat-Mode Block Transfer Controller

This block is a single-channel copy engine. Each pulse on the trigger input starts one activation, which moves a block of N bytes from a source address to a destination address. It reads one byte, then writes that byte, over a byte-wide memory request port. A descriptor loaded through plain configuration ports sets how the engine behaves. It holds the block size, a transfer count, a reload value for that count, the two start addresses, a four-bit mode code and an interrupt enable.

One side of the copy is the repeat area. That side walks forward through memory, and when the transfer count expires it jumps back to the address it held at load time. The other side either walks forward or stays on one address. When the count expires it is refilled from the reload value, so the engine keeps running with no further configuration. It can also pulse an interrupt at that point.

The memory request channel is valid/ready. The engine raises `mem_req_valid` together with the address, direction and write data. It holds all of them unchanged until `mem_req_ready` is sampled high, and the transfer takes place on the clock edge where both are high. Read data comes back on `mem_rvalid`/`mem_rdata` at any later cycle. The engine always accepts it and has no ready signal on that path.

Top module: `rpt_xfer_engine`

## Requirements
- R1: Each activation performs exactly N read/write pairs. Each pair is one read request, then one write request that carries the byte returned for that read.
- R2: Mode code bits [3:0] are decoded as follows. `xx11` makes the source the repeat area, and bit 3 chooses the destination behaviour (0 = walks forward, 1 = fixed). `x?01` with bit 1 equal to 0 makes the destination the repeat area, and bit 2 chooses the source behaviour (0 = walks forward, 1 = fixed). Any code with bit 0 equal to 0 is rejected.
- R3: Within an activation, a side that walks forward (including the repeat side) uses its base address plus the byte index. A fixed side uses the same address for every byte. Between activations, a side that walks forward advances by N and a fixed side does not move.
- R4: An activation that starts with the count at 1 sends the repeat side back to its address captured at load and reloads the count from the reload value. Any other activation lowers the count by one.
- R5: When the interrupt enable is 1, `irq` is high for exactly one cycle, in the cycle after the final write handshake of an activation that started with the count at 1. At all other times it stays low.
- R6: `busy` rises in the cycle after an accepted trigger and falls in the cycle after the final write handshake. Requests are only issued while `busy` is high.
- R7: Triggers that arrive while busy leave exactly one pending activation, however many there are. That activation runs right after the current one ends.
- R8: A load is rejected when any of the following holds: block size is 0, count is 0, reload is 0, the mode code is invalid, or the low 8 bits of the repeat-side address are not 00h. A rejected load sets `cfg_err` and leaves no usable descriptor, so later triggers cause no requests. A valid load clears `cfg_err`. Before the first load, triggers are ignored.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the valid, address, direction and write data stay unchanged.
- R10: A load presented while busy is ignored. The descriptor, the progress through it and `cfg_err` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load descriptor fields (one-cycle pulse) |
| cfg_blk | input | BW | Block size N in bytes |
| cfg_count | input | CW | Initial transfer count |
| cfg_reload | input | CW | Count reload value |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_mode | input | 4 | Mode code (see R2) |
| cfg_irq_en | input | 1 | Enable interrupt on count expiry |
| trig | input | 1 | Activation request |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | 8 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Activation in progress |
| irq | output | 1 | One-cycle count-expiry interrupt |
| cfg_err | output | 1 | Last accepted load was rejected |

## Verification
A wrong working pointer shows up on the very next write handshake as a bad write address. Because each written byte is derived from its read address, a wrong source pointer also shows up there, as bad write data. A wrong count or a missed reload stays hidden until the activation that should wrap. In that activation the repeat side fails to return to its start and the interrupt pulse goes missing or appears in the wrong place. Runs must therefore span at least two full count periods. A pending flag stuck high or low shows within a few cycles of the current activation ending, either as an extra write with nothing queued for it or as writes that were expected but never arrive.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RD    = 2'd1,
    S_RWAIT = 2'd2,
    S_WR    = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic ok;       // code is a legal repeat-mode code
    logic src_rpt;  // 1: source wraps, 0: destination wraps
    logic src_fix;  // source address held
    logic dst_fix;  // destination address held
  } mode_t;

  function automatic mode_t decode_mode(input logic [3:0] code);
    mode_t d;
    d = '0;
    if (code[1:0] == 2'b11) begin
      d.ok      = 1'b1;
      d.src_rpt = 1'b1;
      d.dst_fix = code[3];
    end else if (code[1:0] == 2'b01) begin
      d.ok      = 1'b1;
      d.src_fix = code[2];
    end
    return d;
  endfunction

endpackage

// File: rtl/rpt_desc.sv
module rpt_desc
  import rpt_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [BW-1:0] ld_blk,
  input  logic [CW-1:0] ld_cnt,
  input  logic [CW-1:0] ld_rld,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [3:0]    ld_mode,
  input  logic          ld_ien,
  input  logic          step,
  input  logic          act_end,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [BW-1:0] blk,
  output logic          wrap,
  output logic          ien,
  output logic          valid,
  output logic          err
);
  logic [BW-1:0] blk_q;
  logic [CW-1:0] cnt_q, rld_q;
  logic [AW-1:0] src_q, dst_q, init_q;
  mode_t         md_q, md_n;
  logic          ien_q, valid_q, err_q;
  logic [AW-1:0] rpt_start;
  logic          bad;

  always_comb begin
    md_n      = decode_mode(ld_mode);
    rpt_start = md_n.src_rpt ? ld_src : ld_dst;
    bad = !md_n.ok || (ld_blk == '0) || (ld_cnt == '0) ||
          (ld_rld == '0) || (rpt_start[7:0] != 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      cnt_q   <= '0;
      rld_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      init_q  <= '0;
      md_q    <= '0;
      ien_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (ld) begin
      blk_q   <= ld_blk;
      cnt_q   <= ld_cnt;
      rld_q   <= ld_rld;
      src_q   <= ld_src;
      dst_q   <= ld_dst;
      init_q  <= rpt_start;
      md_q    <= md_n;
      ien_q   <= ld_ien;
      valid_q <= !bad;
      err_q   <= bad;
    end else begin
      if (step) begin
        src_q <= src_q + AW'(!md_q.src_fix);
        dst_q <= dst_q + AW'(!md_q.dst_fix);
      end
      if (act_end) begin
        if (cnt_q == CW'(1)) begin
          cnt_q <= rld_q;
          if (md_q.src_rpt) src_q <= init_q;
          else              dst_q <= init_q;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign blk      = blk_q;
  assign wrap     = (cnt_q == CW'(1));
  assign ien      = ien_q;
  assign valid    = valid_q;
  assign err      = err_q;

endmodule

// File: rtl/rpt_seq.sv
module rpt_seq
  import rpt_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          clr,
  input  logic          desc_ok,
  input  logic [BW-1:0] blk,
  input  logic          wrap,
  input  logic          ien,
  input  logic          req_ready,
  input  logic          rvalid,
  input  logic [7:0]    rdata,
  output logic          req_valid,
  output logic          req_we,
  output logic [7:0]    wdata,
  output logic          step,
  output logic          act_end,
  output logic          busy,
  output logic          irq
);
  seq_st_e       st;
  logic [BW-1:0] nbytes;
  logic          pend, irq_q, start, last;
  logic [7:0]    data_q;

  assign busy      = (st != S_IDLE);
  assign start     = (st == S_IDLE) && desc_ok && (trig || pend);
  assign last      = (nbytes == blk - BW'(1));
  assign req_valid = (st == S_RD) || (st == S_WR);
  assign req_we    = (st == S_WR);
  assign step      = (st == S_WR) && req_ready;
  assign act_end   = step && last;
  assign wdata     = data_q;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      nbytes <= '0;
      pend   <= 1'b0;
      irq_q  <= 1'b0;
      data_q <= '0;
    end else begin
      irq_q <= act_end && wrap && ien;
      if (clr)               pend <= 1'b0;
      else if (busy && trig) pend <= 1'b1;
      else if (start)        pend <= 1'b0;
      case (st)
        S_IDLE:  if (start) begin
                   st     <= S_RD;
                   nbytes <= '0;
                 end
        S_RD:    if (req_ready) st <= S_RWAIT;
        S_RWAIT: if (rvalid) begin
                   data_q <= rdata;
                   st     <= S_WR;
                 end
        S_WR:    if (req_ready) begin
                   if (last) st <= S_IDLE;
                   else begin
                     st     <= S_RD;
                     nbytes <= nbytes + BW'(1);
                   end
                 end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rpt_xfer_engine.sv
module rpt_xfer_engine
  import rpt_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [BW-1:0] cfg_blk,
  input  logic [CW-1:0] cfg_count,
  input  logic [CW-1:0] cfg_reload,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [3:0]    cfg_mode,
  input  logic          cfg_irq_en,
  input  logic          trig,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [7:0]    mem_req_wdata,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          irq,
  output logic          cfg_err
);
  logic          ld_ok, step, act_end, wrap, ien, desc_ok;
  logic [AW-1:0] src_addr, dst_addr;
  logic [BW-1:0] blk;

  // loads are only taken between activations
  assign ld_ok = cfg_load && !busy;

  rpt_desc #(.AW(AW), .BW(BW), .CW(CW)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld_ok),
    .ld_blk   (cfg_blk),
    .ld_cnt   (cfg_count),
    .ld_rld   (cfg_reload),
    .ld_src   (cfg_src),
    .ld_dst   (cfg_dst),
    .ld_mode  (cfg_mode),
    .ld_ien   (cfg_irq_en),
    .step     (step),
    .act_end  (act_end),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .blk      (blk),
    .wrap     (wrap),
    .ien      (ien),
    .valid    (desc_ok),
    .err      (cfg_err)
  );

  rpt_seq #(.BW(BW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .clr       (ld_ok),
    .desc_ok   (desc_ok),
    .blk       (blk),
    .wrap      (wrap),
    .ien       (ien),
    .req_ready (mem_req_ready),
    .rvalid    (mem_rvalid),
    .rdata     (mem_rdata),
    .req_valid (mem_req_valid),
    .req_we    (mem_req_we),
    .wdata     (mem_req_wdata),
    .step      (step),
    .act_end   (act_end),
    .busy      (busy),
    .irq       (irq)
  );

  assign mem_req_addr = mem_req_we ? dst_addr : src_addr;

endmodule

// File: rtl/rpt_xfer_engine_chk.sv
module rpt_xfer_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [7:0]    mem_req_wdata,
  input logic          busy,
  input logic          irq,
  input logic          cfg_err
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R6
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_req_valid && mem_req_ready && mem_req_we));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

endmodule

bind rpt_xfer_engine rpt_xfer_engine_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .busy          (busy),
  .irq           (irq),
  .cfg_err       (cfg_err)
);

// File: tb/rpt_xfer_engine_bench.sv
module rpt_xfer_engine_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [7:0]    cfg_blk = '0, cfg_count = '0, cfg_reload = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [3:0]    cfg_mode = '0;
  logic          cfg_irq_en = 1'b0, trig = 1'b0;
  logic          mem_req_valid, mem_req_we, busy, irq, cfg_err;
  logic          mem_req_ready = 1'b1, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [7:0]    mem_req_wdata, mem_rdata = '0;

  rpt_xfer_engine #(.AW(AW), .BW(8), .CW(8)) u_rpt_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_blk(cfg_blk),
    .cfg_count(cfg_count), .cfg_reload(cfg_reload), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_mode(cfg_mode), .cfg_irq_en(cfg_irq_en),
    .trig(trig), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .irq(irq), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         tag;
  } wr_t;
  wr_t exp_q[$];

  int  irq_seen = 0, exp_irq = 0;
  bit  bp_en = 0;
  logic [7:0] lfsr = 8'h5B;

  // descriptor model
  logic [AW-1:0] m_src, m_dst, m_init;
  int  m_cnt, m_rld, m_n;
  bit  m_srpt, m_sfix, m_dfix, m_ien, m_wrapped;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model with optional back-pressure
  always @(posedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= bp_en ? lfsr[0] : 1'b1;
    mem_rvalid    <= mem_req_valid && mem_req_ready && !mem_req_we;
    mem_rdata     <= pat(mem_req_addr);
  end

  // monitor: scoreboard pop and compare
  bit            prev_stall = 0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "held request addr",
            mem_req_addr, prev_addr);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready && mem_req_we) begin
        if (exp_q.size() == 0) begin
          chk(0, "R1", "unexpected write", mem_req_addr, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(mem_req_addr == e.a, e.tag, "write addr", mem_req_addr, e.a);
          chk(mem_req_wdata == e.d, "R1", "write data", mem_req_wdata, e.d);
        end
      end
      if (irq) irq_seen++;
    end
  end

  task automatic push_act();
    string tg;
    tg = m_wrapped ? "R4" : "R3";
    for (int i = 0; i < m_n; i++) begin
      wr_t e;
      logic [AW-1:0] sa, da;
      sa = m_sfix ? m_src : m_src + AW'(i);
      da = m_dfix ? m_dst : m_dst + AW'(i);
      e.a = da; e.d = pat(sa); e.tag = tg;
      exp_q.push_back(e);
    end
    if (!m_sfix) m_src = m_src + AW'(m_n);
    if (!m_dfix) m_dst = m_dst + AW'(m_n);
    m_wrapped = (m_cnt == 1);
    if (m_cnt == 1) begin
      if (m_ien) exp_irq++;
      if (m_srpt) m_src = m_init; else m_dst = m_init;
      m_cnt = m_rld;
    end else m_cnt--;
  endtask

  task automatic load(input logic [3:0] md, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input int n, input int c, input int r, input bit ie,
                      input bit exp_err, input string req);
    @(negedge clk);
    cfg_load = 1; cfg_mode = md; cfg_src = s; cfg_dst = d;
    cfg_blk = 8'(n); cfg_count = 8'(c); cfg_reload = 8'(r); cfg_irq_en = ie;
    @(negedge clk);
    cfg_load = 0;
    chk(cfg_err == exp_err, req, "cfg_err after load", cfg_err, exp_err);
    if (!exp_err) begin
      m_srpt = (md[1:0] == 2'b11);
      m_sfix = !m_srpt && md[2];
      m_dfix = m_srpt && md[3];
      m_src = s; m_dst = d; m_init = m_srpt ? s : d;
      m_n = n; m_cnt = c; m_rld = r; m_ien = ie; m_wrapped = 0;
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic drain();
    int k;
    k = 0;
    while ((exp_q.size() != 0 || busy) && k < 5000) begin
      @(negedge clk); k++;
    end
    @(negedge clk);
  endtask

  task automatic run_acts(input int k);
    for (int a = 0; a < k; a++) begin
      push_act();
      pulse_trig();
      chk(busy == 1, "R6", "busy after trigger", busy, 1);
      drain();
      chk(exp_q.size() == 0, "R1", "writes outstanding", exp_q.size(), 0);
      chk(irq_seen == exp_irq, "R5", "irq count", irq_seen, exp_irq);
    end
  endtask

  task automatic quiet_check(input string req);
    pulse_trig();
    repeat (20) begin
      @(negedge clk);
      if (busy) begin chk(0, req, "busy on ignored trigger", busy, 0); break; end
    end
    chk(busy == 0, req, "idle after ignored trigger", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R6", "reset busy", busy, 0);
    chk(irq == 0, "R5", "reset irq", irq, 0);
    chk(mem_req_valid == 0, "R6", "reset req_valid", mem_req_valid, 0);
    chk(cfg_err == 0, "R8", "reset cfg_err", cfg_err, 0);
    quiet_check("R8");

    // source repeat, destination walks
    load(4'b0011, 16'h1200, 16'h3400, 4, 3, 2, 1, 0, "R2");
    run_acts(6);
    // source repeat, destination fixed, back-pressure
    bp_en = 1;
    load(4'b1111, 16'h2300, 16'h4444, 5, 2, 3, 1, 0, "R2");
    run_acts(5);
    // destination repeat, source walks, no interrupt
    load(4'b1001, 16'h1234, 16'h5600, 3, 2, 2, 0, 0, "R2");
    run_acts(5);
    chk(irq_seen == exp_irq, "R5", "no irq when disabled", irq_seen, exp_irq);
    // destination repeat, source fixed, single byte, count 1
    load(4'b0101, 16'h7777, 16'h8100, 1, 1, 1, 1, 0, "R2");
    run_acts(3);
    bp_en = 0;

    // rejected loads
    load(4'b0011, 16'h1200, 16'h3400, 0, 3, 2, 1, 1, "R8");
    quiet_check("R8");
    load(4'b0011, 16'h1200, 16'h3400, 4, 0, 2, 1, 1, "R8");
    load(4'b0011, 16'h1200, 16'h3400, 4, 3, 0, 1, 1, "R8");
    load(4'b0011, 16'h1210, 16'h3400, 4, 3, 2, 1, 1, "R8");
    load(4'b0010, 16'h1200, 16'h3400, 4, 3, 2, 1, 1, "R2");
    load(4'b1000, 16'h1200, 16'h3400, 4, 3, 2, 1, 1, "R2");
    quiet_check("R2");
    load(4'b0111, 16'h1200, 16'h3400, 4, 3, 2, 1, 0, "R2");
    // repeat-side rule only applies to the repeat side
    load(4'b0001, 16'h1210, 16'h3400, 2, 2, 2, 0, 0, "R8");
    run_acts(1);

    // pending collapse
    load(4'b0011, 16'h0900, 16'hA000, 6, 4, 4, 0, 0, "R7");
    push_act(); push_act();
    pulse_trig();
    repeat (2) @(negedge clk);
    pulse_trig(); pulse_trig(); pulse_trig();
    drain();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "pending activation ran", exp_q.size(), 0);
    chk(busy == 0, "R7", "single pending only", busy, 0);

    // load while busy
    push_act();
    pulse_trig();
    @(negedge clk);
    cfg_load = 1; cfg_blk = 8'd0; cfg_mode = 4'b0010;
    @(negedge clk);
    cfg_load = 0;
    drain();
    chk(cfg_err == 0, "R10", "cfg_err after busy load", cfg_err, 0);
    run_acts(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule